// File: doc/BRIEF.md
# SDRAM Line Burst-Write Sequencer

This block performs one burst write of a 32-byte cache line into a single bank of synchronous DRAM over a 32-bit data bus. A request carries a bank, a row and a column. The three low column bits name the word where the burst starts inside the line. When the request is taken, the block opens the row and waits a configurable row-to-column gap. It then issues a write with auto-precharge and streams eight words, wrapping modulo eight inside the line-aligned block. The data is pulled from the requester one word per cycle through an index output.

After the last word the bank stays locked. First come a configurable number of write-recovery cycles, then a configurable precharge wait. A busy output covers the whole sequence, and no new request is taken until it falls. The three wait counts are static configuration inputs.

Top module: `sdram_burst_writer`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the last precharge-wait cycle. `req_valid` has no effect while `busy` is high, and the request fields are latched when the request is taken.
- R2: In the first cycle after acceptance the pins carry a row-activate command: `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=1, with the latched row on `sd_addr` and the bank on `sd_ba`. `sd_bs` is high in that cycle only.
- R3: Between the activate cycle and the first data cycle there are exactly `cfg_trcd` command-free cycles. A value of 0 counts as 1.
- R4: The first data cycle carries a write with auto-precharge: `sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=0, `sd_we_n`=0, `sd_addr[10]`=1. The column bits `sd_addr[COL_W-1:0]` equal the latched column: line bits above, start word in bits [2:0].
- R5: There are eight consecutive data cycles. In data cycle k (k=0..7), `data_idx` = (start word + k) mod 8, `data_take`=1, `sd_dq_oe`=1, `sd_dq` equals `wdata`, and `sd_dqm`=0.
- R6: After the eighth data cycle there are exactly `cfg_trwl` (0 to 7) write-recovery cycles with `busy` high and no command.
- R7: The recovery cycles are followed by exactly `cfg_tpc` precharge-wait cycles, with 0 counting as 1. `busy` falls in the cycle after the last of them.
- R8: In every cycle that carries no command, `sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` are all 1. `sd_cke` is 1 at all times, and `sd_dq_oe` is 0 outside data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request a line write |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ADDR_W | Row address |
| req_col | input | COL_W | Column; bits [2:0] are the start word |
| cfg_trcd | input | 2 | Row-to-column wait cycles (0 acts as 1) |
| cfg_trwl | input | 3 | Write-recovery cycles |
| cfg_tpc | input | 2 | Precharge-wait cycles (0 acts as 1) |
| wdata | input | DATA_W | Word selected by data_idx |
| busy | output | 1 | Sequence in progress, bank locked |
| data_take | output | 1 | wdata is consumed this cycle |
| data_idx | output | 3 | Word of the line wanted this cycle |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row/column address |
| sd_dq | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | DATA_W/8 | Byte masks, active high |
| sd_bs | output | 1 | Bus-cycle start strobe |

## Verification
The hardest behaviour to show from the ports is that a request held high through the whole locked window is ignored. The bench keeps `req_valid` asserted with changed address fields until the negative edge of the last precharge-wait cycle. The expected cycle stream must then show no second activate, and the first burst must keep its original address. Other runs use extreme wait settings: a zero recovery count, the maximum of seven, and zero for both minimum-one waits. They also cover start words 0, 3, 5 and 7, so the wrap falls at every position in the burst.

// File: rtl/sdw_pkg.sv
// Shared types for the SDRAM line burst-write sequencer.
// Assumes a fixed eight-beat burst covering one line.
package sdw_pkg;
    localparam int BEATS  = 8;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACT,
        PH_RCD,
        PH_DATA,
        PH_RWL,
        PH_PCH
    } phase_t;
endpackage

// File: rtl/sdw_seq_ctrl.sv
// Phase controller: walks activate, row-to-column gap, eight data beats,
// write recovery and precharge wait. Assumes configuration is stable
// while a sequence runs. Zero gap/precharge counts are raised to one.
module sdw_seq_ctrl
    import sdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_trcd,
    input  logic [2:0]        cfg_trwl,
    input  logic [1:0]        cfg_tpc,
    output phase_t            phase,
    output logic [BEAT_W-1:0] beat
);
    logic [2:0] cnt;
    logic [2:0] rcd_last;
    logic [2:0] pch_last;

    // Purpose: terminal values for the minimum-one waits.
    always_comb begin
        rcd_last = (cfg_trcd == 2'd0) ? 3'd0 : 3'({cfg_trcd} - 2'd1);
        pch_last = (cfg_tpc  == 2'd0) ? 3'd0 : 3'({cfg_tpc}  - 2'd1);
    end

    // Purpose: phase register, down-counter for waits, beat up-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            beat  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) phase <= PH_ACT;
                PH_ACT: begin
                    phase <= PH_RCD;
                    cnt   <= rcd_last;
                end
                PH_RCD: begin
                    if (cnt == 3'd0) begin
                        phase <= PH_DATA;
                        beat  <= '0;
                    end else begin
                        cnt <= cnt - 3'd1;
                    end
                end
                PH_DATA: begin
                    if (beat == BEAT_W'(BEATS - 1)) begin
                        if (cfg_trwl == 3'd0) begin
                            phase <= PH_PCH;
                            cnt   <= pch_last;
                        end else begin
                            phase <= PH_RWL;
                            cnt   <= cfg_trwl - 3'd1;
                        end
                    end
                    beat <= beat + 1'b1;
                end
                PH_RWL: begin
                    if (cnt == 3'd0) begin
                        phase <= PH_PCH;
                        cnt   <= pch_last;
                    end else begin
                        cnt <= cnt - 3'd1;
                    end
                end
                PH_PCH: begin
                    if (cnt == 3'd0) phase <= PH_IDLE;
                    else             cnt   <= cnt - 3'd1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DATA_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_RCD); // R3
    AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && beat != BEAT_W'(BEATS - 1)) |=> phase == PH_DATA); // R5
    AST_IDLE_FROM_PCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase) != PH_IDLE) |-> $past(phase) == PH_PCH); // R7
endmodule

// File: rtl/sdw_wrap_idx.sv
// Wraparound word index: start word plus beat number, modulo the line
// size. Assumes the line holds a power-of-two count of words.
module sdw_wrap_idx
    import sdw_pkg::*;
(
    input  logic [BEAT_W-1:0] start_word,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] word
);
    // Purpose: modular add; the carry out is dropped by width.
    always_comb word = start_word + beat;
endmodule

// File: rtl/sdram_burst_writer.sv
// SDRAM line burst-write sequencer top. Takes one request when idle,
// latches it, and drives activate, write-with-auto-precharge and eight
// wrapped data beats, then holds the bank through recovery and precharge.
// Assumes COL_W fits below the auto-precharge address bit.
module sdram_burst_writer
    import sdw_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [ADDR_W-1:0]     req_row,
    input  logic [COL_W-1:0]      req_col,
    input  logic [1:0]            cfg_trcd,
    input  logic [2:0]            cfg_trwl,
    input  logic [1:0]            cfg_tpc,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  busy,
    output logic                  data_take,
    output logic [2:0]            data_idx,
    output logic                  sd_cke,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [BANK_W-1:0]     sd_ba,
    output logic [ADDR_W-1:0]     sd_addr,
    output logic [DATA_W-1:0]     sd_dq,
    output logic                  sd_dq_oe,
    output logic [DATA_W/8-1:0]   sd_dqm,
    output logic                  sd_bs
);
    localparam int LINE_W = COL_W - BEAT_W;

    phase_t              phase;
    logic [BEAT_W-1:0]   beat;
    logic [BEAT_W-1:0]   word;
    logic                start;
    logic [BANK_W-1:0]   r_bank;
    logic [ADDR_W-1:0]   r_row;
    logic [LINE_W-1:0]   r_line;
    logic [BEAT_W-1:0]   r_start;
    logic                is_act;
    logic                is_wr;
    logic                in_data;
    logic [ADDR_W-1:0]   col_addr;

    // Purpose: accept a request only while idle.
    always_comb start = req_valid && (phase == PH_IDLE);

    // Purpose: latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_bank  <= '0;
            r_row   <= '0;
            r_line  <= '0;
            r_start <= '0;
        end else if (start) begin
            r_bank  <= req_bank;
            r_row   <= req_row;
            r_line  <= req_col[COL_W-1:BEAT_W];
            r_start <= req_col[BEAT_W-1:0];
        end
    end

    sdw_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_trcd (cfg_trcd),
        .cfg_trwl (cfg_trwl),
        .cfg_tpc  (cfg_tpc),
        .phase    (phase),
        .beat     (beat)
    );

    sdw_wrap_idx i_wrap (
        .start_word (r_start),
        .beat       (beat),
        .word       (word)
    );

    // Purpose: decode the phase into command and data-cycle flags.
    always_comb begin
        is_act  = (phase == PH_ACT);
        in_data = (phase == PH_DATA);
        is_wr   = in_data && (beat == '0);
    end

    // Purpose: column address with the auto-precharge bit set.
    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = {r_line, r_start};
        col_addr[AP_BIT]      = 1'b1;
    end

    // Purpose: drive the SDRAM pins and the data-pull interface.
    always_comb begin
        busy      = (phase != PH_IDLE);
        sd_cke    = 1'b1;
        sd_bs     = is_act;
        sd_cs_n   = !(is_act || is_wr);
        sd_ras_n  = !is_act;
        sd_cas_n  = !is_wr;
        sd_we_n   = !is_wr;
        sd_ba     = r_bank;
        sd_addr   = is_act ? r_row : (is_wr ? col_addr : '0);
        data_take = in_data;
        data_idx  = word;
        sd_dq_oe  = in_data;
        sd_dq     = in_data ? wdata : '0;
        sd_dqm    = in_data ? '0 : '1;
    end

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sd_bs); // R1
    AST_BS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_bs |=> !sd_bs); // R2
    AST_BS_WITH_ACTV: assert property (@(posedge clk) disable iff (!rst_n)
        sd_bs |-> (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n)); // R2
    AST_WRITA_AP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_we_n) |-> (sd_addr[AP_BIT] && sd_dq_oe && data_take)); // R4
    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_take && $past(data_take)) |-> data_idx == 3'($past(data_idx) + 3'd1)); // R5
    AST_DQM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> sd_dqm == '0); // R5
    AST_NOP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cs_n |-> (sd_ras_n && sd_cas_n && sd_we_n && sd_cke)); // R8
endmodule

// File: tb/test_sdram_burst_writer.sv
// Scoreboard bench: the driver task builds the expected pin stream of a
// transaction from the requirements and queues it; the monitor pops one
// item per cycle, 2 ns after the rising edge, and compares.
module test_sdram_burst_writer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [7:0]  req_col;
    logic [1:0]  cfg_trcd;
    logic [2:0]  cfg_trwl;
    logic [1:0]  cfg_tpc;
    logic [31:0] wdata;
    logic        busy, data_take, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic        sd_dq_oe, sd_bs;
    logic [2:0]  data_idx;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [31:0] sd_dq;
    logic [3:0]  sd_dqm;

    logic [31:0] line [8];
    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic        cs, ras, cas, we, bs, busy, oe, chk_addr;
        logic [12:0] addr;
        logic [1:0]  ba;
        logic [31:0] dq;
        int          rq;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    assign wdata = line[data_idx];

    sdram_burst_writer i_sdram_burst_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .cfg_trcd(cfg_trcd),
        .cfg_trwl(cfg_trwl), .cfg_tpc(cfg_tpc), .wdata(wdata), .busy(busy),
        .data_take(data_take), .data_idx(data_idx), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq),
        .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm), .sd_bs(sd_bs)
    );

    function automatic exp_t nop_item(input logic bsy, input int rq);
        exp_t e;
        e.cs = 1; e.ras = 1; e.cas = 1; e.we = 1; e.bs = 0; e.busy = bsy;
        e.oe = 0; e.chk_addr = 0; e.addr = '0; e.ba = '0; e.dq = '0; e.rq = rq;
        return e;
    endfunction

    // Monitor: compare one queued item per cycle.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            logic bad;
            e = q.pop_front();
            n_tests++;
            bad = (sd_cs_n !== e.cs) || (sd_ras_n !== e.ras) || (sd_cas_n !== e.cas)
               || (sd_we_n !== e.we) || (sd_bs !== e.bs) || (busy !== e.busy)
               || (sd_dq_oe !== e.oe) || (data_take !== e.oe) || (sd_cke !== 1'b1);
            if (e.chk_addr) bad = bad || (sd_addr !== e.addr) || (sd_ba !== e.ba);
            if (e.oe) bad = bad || (sd_dq !== e.dq) || (sd_dqm !== 4'h0);
            if (bad) begin
                n_fail++;
                $display("FAIL R%0d: act cs%b ras%b cas%b we%b bs%b busy%b oe%b take%b ba%h addr%h dq%h dqm%h | exp cs%b ras%b cas%b we%b bs%b busy%b oe%b ba%h addr%h dq%h",
                    e.rq, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_bs, busy, sd_dq_oe,
                    data_take, sd_ba, sd_addr, sd_dq, sd_dqm, e.cs, e.ras, e.cas, e.we,
                    e.bs, e.busy, e.oe, e.ba, e.addr, e.dq);
            end
        end
    end

    // Driver: set config, issue one request, queue the expected stream.
    task automatic run_txn(input logic [1:0] ba, input logic [12:0] row,
                           input logic [7:0] col, input logic [1:0] trcd,
                           input logic [2:0] trwl, input logic [1:0] tpc,
                           input logic hold, input logic [31:0] seed);
        exp_t e;
        int r, p, total;
        r = (trcd == 0) ? 1 : int'(trcd);
        p = (tpc == 0) ? 1 : int'(tpc);
        total = 1 + r + 8 + int'(trwl) + p;
        for (int i = 0; i < 8; i++) line[i] = seed ^ (32'h0101_0101 * (i + 1));
        @(negedge clk);
        cfg_trcd = trcd; cfg_trwl = trwl; cfg_tpc = tpc;
        req_bank = ba; req_row = row; req_col = col; req_valid = 1'b1;
        // R2: activate with row and bank, strobe high
        e = nop_item(1'b1, 2);
        e.cs = 0; e.ras = 0; e.bs = 1; e.chk_addr = 1; e.addr = row; e.ba = ba;
        q.push_back(e);
        for (int i = 0; i < r; i++) q.push_back(nop_item(1'b1, 3)); // R3 gap
        for (int k = 0; k < 8; k++) begin                            // R5 beats
            e = nop_item(1'b1, 5);
            e.oe = 1; e.dq = line[(int'(col[2:0]) + k) % 8];
            if (k == 0) begin                                        // R4 write
                e.rq = 4; e.cs = 0; e.cas = 0; e.we = 0; e.chk_addr = 1; e.ba = ba;
                e.addr = 13'h0400 | 13'(col);
            end
            q.push_back(e);
        end
        for (int i = 0; i < int'(trwl); i++) q.push_back(nop_item(1'b1, 6)); // R6
        for (int i = 0; i < p; i++) q.push_back(nop_item(1'b1, 7));          // R7
        q.push_back(nop_item(1'b0, hold ? 1 : 7));  // R1/R7: busy has fallen
        @(posedge clk);
        @(negedge clk);
        if (hold) begin
            // R1: keep requesting with other fields while busy
            req_bank = ~ba; req_row = ~row; req_col = ~col;
            repeat (total - 1) @(negedge clk);
        end
        req_valid = 1'b0;
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, exp done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
        cfg_trcd = 2'd1; cfg_trwl = 3'd0; cfg_tpc = 2'd1;
        for (int i = 0; i < 8; i++) line[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (busy !== 1'b0 || sd_cs_n !== 1'b1 || sd_bs !== 1'b0 || sd_cke !== 1'b1
            || sd_dq_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset: busy%b cs%b bs%b cke%b oe%b exp 0 1 0 1 0",
                busy, sd_cs_n, sd_bs, sd_cke, sd_dq_oe);
        end
        run_txn(2'd1, 13'h0ABC, 8'h30, 2'd1, 3'd0, 2'd1, 1'b0, 32'hA5A5_0000);
        run_txn(2'd2, 13'h1234, 8'hC5, 2'd0, 3'd7, 2'd3, 1'b0, 32'h1357_9BDF);
        run_txn(2'd3, 13'h0F0F, 8'h57, 2'd3, 3'd2, 2'd0, 1'b1, 32'hDEAD_BEEF);
        run_txn(2'd0, 13'h1FFF, 8'hFB, 2'd2, 3'd4, 2'd2, 1'b0, 32'h0BAD_F00D);
        run_txn(2'd1, 13'h0001, 8'h00, 2'd3, 3'd7, 2'd3, 1'b1, 32'h7777_1111);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule